// File: doc/BRIEF.md
# Prescaled Register-Controlled PWM Generator

This block drives one pulse-width-modulated output from a slow reference tick, nominally 32 kHz, given as a one-cycle enable in the fast system clock domain. An 8-bit counter advances once per tick. There is no period register. A 2-bit prescaler instead selects which counter bit ends a period, which gives periods of 128, 64, 32 or 16 ticks (250 Hz, 500 Hz, 1 kHz and 2 kHz at 32 kHz). The counter bits below the selected bit form the active count. The output is high while that count is below a 7-bit duty value.

Software configures the block through two byte-wide registers. These sit behind a one-bit address, a write strobe and a combinational read port. One register holds the enable and the prescaler, and the other holds the duty value. Each is written on its own. A prescaler change does not clear the counter, and a duty change acts at once rather than at the end of the period. Because the duty field has only 7 bits, the slowest setting cannot produce a fully high output.

Top module: `pwm_gen`

## Requirements
- R1: A synchronous reset clears both registers and the counter: the block is disabled, prescaler 0, duty 0, and `pwm_out` is low.
- R2: While enabled, the counter advances only in cycles where `tick_en` is high. For prescaler p, the counter returns to zero on the tick that would set bit 7−p. This gives a period of 128, 64, 32 or 16 ticks for p = 0, 1, 2, 3.
- R3: While enabled, `pwm_out` is high exactly when the counter masked to bits [6−p:0] is below the duty value. A duty of 0 gives a constant low.
- R4: A duty value of 2^(7−p) or more keeps `pwm_out` high for the whole period.
- R5: At prescaler 0 the largest duty value, 127, still leaves `pwm_out` low for exactly one tick in every 128.
- R6: Writing a new prescaler leaves the counter value unchanged. Counting continues from that value under the new reset bit.
- R7: A duty write is used by the compare in the cycle after the write strobe, in the middle of a period, with no wait for the period end.
- R8: While the enable is clear, the counter is held at zero and `pwm_out` is low. Setting the enable starts the count from zero.
- R9: Reads are combinational. Address 0 returns the enable in bit 7 and the prescaler in bits [1:0], with bits [6:2] as zero. Address 1 returns the duty in bits [6:0], with bit 7 as zero. Bit 7 of a duty write and bits [6:2] of a control write are discarded.
- R10: A write to one address leaves the other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle reference tick enable (nominally 32 kHz) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register address: 0 control, 1 duty |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| pwm_out | output | 1 | PWM output |

## Verification
A register write at a clock edge changes `pwm_out` from that edge on: the compare is combinational from the registers, so a new duty or enable shows one edge after the strobe. A tick at an edge moves the counter at that same edge, and `pwm_out` follows in the same cycle. The bench applies writes and ticks to its behavioural model at each rising edge, using the register values from before the edge for the counter step, and compares `pwm_out` at every falling edge. Reads are combinational, so they are checked a short delay after the address changes, with no clock edge in between.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int CNT_W  = 8;
    localparam int PS_W   = 2;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 1;
    localparam int DUTY_W = CNT_W - 1;
    localparam int NUM_PS = 1 << PS_W;
    localparam int EN_BIT = DATA_W - 1;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_DUTY = ADDR_W'(1);

    typedef struct packed {
        logic            en;
        logic [PS_W-1:0] presc;
    } ctrl_t;

    // index of the counter bit that ends a period for setting p
    function automatic int wrap_bit(input int p);
        return CNT_W - 1 - p;
    endfunction

    // mask of the counter bits that form the active count for setting p
    function automatic logic [CNT_W-1:0] count_mask(input int p);
        return CNT_W'((1 << wrap_bit(p)) - 1);
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl,
    output logic [DUTY_W-1:0] duty,
    output logic [DATA_W-1:0] rd_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            duty <= '0;
        end else if (wr_en) begin
            case (addr)
                ADDR_CTRL: begin
                    ctrl.en    <= wr_data[EN_BIT];
                    ctrl.presc <= wr_data[PS_W-1:0];
                end
                ADDR_DUTY: duty <= wr_data[DUTY_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        case (addr)
            ADDR_CTRL: begin
                rd_data[EN_BIT]    = ctrl.en;
                rd_data[PS_W-1:0]  = ctrl.presc;
            end
            ADDR_DUTY: rd_data[DUTY_W-1:0] = duty;
            default: ;
        endcase
    end

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  ctrl_t            ctrl,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W-1:0]  cnt_inc;
    logic [NUM_PS-1:0] wrap_sel;
    logic              wrap;

    assign cnt_inc = cnt + CNT_W'(1);

    genvar g;
    generate
        for (g = 0; g < NUM_PS; g++) begin : g_wrap
            assign wrap_sel[g] = cnt_inc[wrap_bit(g)];
        end
    endgenerate

    assign wrap = wrap_sel[ctrl.presc];

    always_ff @(posedge clk) begin
        if (rst || !ctrl.en) begin
            cnt <= '0;
        end else if (tick_en) begin
            cnt <= wrap ? '0 : cnt_inc;
        end
    end

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare
    import pwm_pkg::*;
(
    input  ctrl_t             ctrl,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [DUTY_W-1:0] duty,
    output logic              pwm_o
);

    logic [CNT_W-1:0] mask_tbl [NUM_PS];
    logic [CNT_W-1:0] active;

    genvar g;
    generate
        for (g = 0; g < NUM_PS; g++) begin : g_mask
            assign mask_tbl[g] = count_mask(g);
        end
    endgenerate

    assign active = cnt & mask_tbl[ctrl.presc];
    assign pwm_o  = ctrl.en && (active < {1'b0, duty});

endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              pwm_out
);

    ctrl_t             ctrl;
    logic [DUTY_W-1:0] duty;
    logic [CNT_W-1:0]  cnt;

    pwm_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .duty    (duty),
        .rd_data (rd_data)
    );

    pwm_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .ctrl    (ctrl),
        .cnt     (cnt)
    );

    pwm_compare u_cmp (
        .ctrl  (ctrl),
        .cnt   (cnt),
        .duty  (duty),
        .pwm_o (pwm_out)
    );

endmodule

// File: rtl/pwm_gen_chk.sv
module pwm_gen_chk
    import pwm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic              en,
    input logic [PS_W-1:0]   presc,
    input logic [DUTY_W-1:0] duty,
    input logic [CNT_W-1:0]  cnt,
    input logic              pwm_out
);

    // R1: a reset cycle leaves counter cleared and output low
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (cnt == '0 && !en && duty == '0));

    // R2: the counter never reaches its top bit
    p_msb_clear_r2: assert property (@(posedge clk) disable iff (rst)
        !cnt[CNT_W-1]);

    // R2: no tick, no movement while enabled
    p_stall_r2: assert property (@(posedge clk) disable iff (rst)
        (en && !tick_en) |=> $stable(cnt));

    // R3: zero duty keeps the output low
    p_zero_duty_r3: assert property (@(posedge clk) disable iff (rst)
        (duty == '0) |-> !pwm_out);

    // R4: duty covering the whole period keeps the output high
    p_full_duty_r4: assert property (@(posedge clk) disable iff (rst)
        (en && int'(duty) >= (1 << (CNT_W - 1 - int'(presc)))) |-> pwm_out);

    // R8: disabled means low output and a counter held at zero
    p_off_low_r8: assert property (@(posedge clk) disable iff (rst)
        !en |-> !pwm_out);
    p_off_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == '0));

endmodule

bind pwm_gen pwm_gen_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .en      (ctrl.en),
    .presc   (ctrl.presc),
    .duty    (duty),
    .cnt     (cnt),
    .pwm_out (pwm_out)
);

// File: tb/tb_pwm_gen.sv
`timescale 1ns/1ps
module tb_pwm_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [0:0] addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       pwm_out;

    int tests = 0;
    int fails = 0;
    string cur_req = "R1";
    int tick_mode = 0;   // 0 every cycle, 1 every third cycle, 2 none
    int tick_div = 0;
    bit done = 0;

    // behavioural model
    int m_en = 0, m_p = 0, m_d = 0, m_cnt = 0;

    pwm_gen dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_p = 0; m_d = 0; m_cnt = 0;
        end else begin
            if (m_en == 0) m_cnt = 0;
            else if (tick_en) begin
                int nxt;
                nxt = m_cnt + 1;
                if (((nxt >> (7 - m_p)) & 1) != 0) m_cnt = 0;
                else m_cnt = nxt;
            end
            if (wr_en) begin
                if (addr == 1'b0) begin
                    m_en = wr_data[7]; m_p = wr_data[1:0];
                end else m_d = wr_data[6:0];
            end
        end
    end

    function automatic bit model_out();
        return (m_en != 0) && ((m_cnt % (1 << (7 - m_p))) < m_d);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison of the output against the model
    always @(negedge clk) begin
        if (!rst && !done) check(cur_req, pwm_out, model_out());
        if (tick_mode == 0) tick_en <= 1'b1;
        else if (tick_mode == 1) begin
            tick_div = (tick_div + 1) % 3;
            tick_en <= (tick_div == 0);
        end else tick_en <= 1'b0;
    end

    task automatic wr(input bit a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input string req, input bit a, input int exp);
        @(negedge clk);
        addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    // count high cycles over a window
    task automatic count_high(input int n, output int hi);
        hi = 0;
        repeat (n) begin
            @(negedge clk);
            #1;
            if (pwm_out) hi++;
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int hi;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        cur_req = "R1";
        rd("R1", 0, 0);
        rd("R1", 1, 0);
        check("R1", pwm_out, 0);

        // R9 readback and discarded bits
        cur_req = "R9";
        wr(0, 8'h7E);            // enable clear, presc 2, bits 6:2 dropped
        rd("R9", 0, 8'h02);
        wr(1, 8'hD5);            // bit 7 dropped
        rd("R9", 1, 8'h55);
        // R10 independent writes
        rd("R10", 0, 8'h02);
        wr(0, 8'h00);
        rd("R10", 1, 8'h55);

        // R8 disabled: output low despite nonzero duty
        cur_req = "R8";
        run(40);
        check("R8", pwm_out, 0);

        // R2/R3 every tick, prescaler 3, duty 5
        cur_req = "R3";
        wr(1, 8'd5);
        wr(0, 8'h83);
        run(3);
        count_high(64, hi);
        check("R2", hi, 20);     // 4 periods of 16, 5 high each
        // R2 other prescalers
        cur_req = "R2";
        wr(0, 8'h82);
        run(40);
        wr(0, 8'h81);
        run(80);
        tick_mode = 1;
        run(300);
        tick_mode = 2;
        run(30);
        tick_mode = 0;

        // R3 duty 0
        cur_req = "R3";
        wr(1, 8'd0);
        count_high(70, hi);
        check("R3", hi, 0);

        // R4 full duty at prescaler 1
        cur_req = "R4";
        wr(0, 8'h81);
        wr(1, 8'd64);
        count_high(128, hi);
        check("R4", hi, 128);
        wr(0, 8'h83);
        wr(1, 8'd16);
        count_high(48, hi);
        check("R4", hi, 48);

        // R5 prescaler 0 duty 127
        cur_req = "R5";
        wr(0, 8'h80);
        wr(1, 8'd127);
        run(130);
        count_high(128, hi);
        check("R5", hi, 127);

        // R6 prescaler change mid-count
        cur_req = "R6";
        wr(1, 8'd40);
        wr(0, 8'h00);
        wr(0, 8'h80);
        run(50);
        wr(0, 8'h83);            // counter near 50, keeps running
        run(100);
        wr(0, 8'h80);
        run(60);

        // R7 mid-period duty change
        cur_req = "R7";
        wr(0, 8'h81);
        run(20);
        wr(1, 8'd10);
        wr(1, 8'd50);
        run(30);
        tick_mode = 1;
        wr(1, 8'd3);
        run(60);
        tick_mode = 0;

        // R8 disable then enable restarts from zero
        cur_req = "R8";
        wr(0, 8'h01);
        run(20);
        check("R8", pwm_out, 0);
        wr(1, 8'd1);
        wr(0, 8'h81);
        #1;
        check("R8", pwm_out, 1); // counter at 0 < duty 1
        run(70);

        // R1 reset mid-run
        cur_req = "R1";
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd("R1", 0, 0);
        rd("R1", 1, 0);
        run(10);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule